// File: doc/BRIEF.md
# Triangle-Carrier Complementary PWM Phase with Clear Suppression

This block drives one phase leg from a triangle carrier. Two up/down counters run between zero and a programmable peak. The lagging counter starts at zero and the leading counter starts at the dead-time value, so the leading one stays ahead of the lagging one by exactly that gap. One compare value sets the duty. The positive output is taken from the lagging counter and the negative output from the leading counter, with the threshold moved down by the dead time. Because of this the two outputs can never overlap. After the counters start, and after most clear requests, both outputs stay at their inactive levels for a short initial-output window.

An external synchronous clear request restarts both counters. Normally a clear also forces the initial-output window. When the suppression enable is set, a clear that lands in the trough interval restarts the counters but keeps the outputs following the compare logic. The trough interval is the span in which either counter sits below the dead-time value. This avoids a sudden jump in the applied duty. Suppression never applies inside the initial-output window that follows a start.

Top module: `cpwm_clrsup`

## Requirements
- R1: While reset is held, each output sits at its inactive level, which is the inverse of its active-level bit. With both level bits at 0 (active-low), both outputs read 1.
- R2: On the clock edge that first samples `start` high, the lagging counter loads 0 and the leading counter loads `dead`, and both count up. Both outputs stay inactive for `dead`+1 cycles from that edge.
- R3: Each counter moves by one per cycle. It turns down when it reaches `period` and turns up when it reaches 0. Outside the initial-output window, `pos_o` is active exactly when the lagging counter is greater than `duty`.
- R4: Outside the initial-output window, `neg_o` is active exactly when the leading counter is less than `duty`-`dead`. That threshold is 0 (never active) when `duty` is not above `dead`.
- R5: `pos_o` and `neg_o` are never active in the same cycle.
- R6: A clear request taken while running, with the trough flag clear, reloads the counters as in R2. It holds both outputs inactive for `dead`+1 cycles whatever `sup_en` is. The trough flag is the previous cycle's value of (lagging < `dead` or leading < `dead`).
- R7: With `sup_en`=1, a clear taken while the trough flag is set and outside the initial-output window reloads the counters but applies no initial-output window. The outputs follow R3/R4 from the next cycle.
- R8: A clear taken inside the initial-output window is never suppressed, even when the trough flag is set.
- R9: With `sup_en`=0, every clear taken while running forces the initial-output window.
- R10: `act_lvl[0]` is the active level of `pos_o` and `act_lvl[1]` is the active level of `neg_o`.
- R11: With `start` low, both outputs go inactive from the next cycle, and clear requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run enable; its rising edge launches the counters |
| clr_req | input | 1 | Synchronous counter-clear request |
| sup_en | input | 1 | Enables suppression of the initial-output window for clears in the trough |
| period | input | CW | Triangle peak value |
| dead | input | CW | Dead-time gap between the counters |
| duty | input | CW | Duty compare value |
| act_lvl | input | 2 | Active level: bit 0 for pos_o, bit 1 for neg_o |
| pos_o | output | 1 | Positive-phase output |
| neg_o | output | 1 | Negative-phase output |

## Verification
The bench sweeps many small configurations of period, dead time, duty, level and enable, with clears at pseudo-random points, and compares every cycle against an arithmetic model. A design that mistimed the one-cycle-late trough flag, or forgot to close the initial-output window, would drift from the model around troughs. Directed cases then take a clear at the peak, in the trough with the enable set and cleared, and in the trough just after start. A design that suppressed the wrong clear would show the negative output active where it should be held inactive, or the reverse. Duty values at or below the dead time, and dead time zero, catch a negative threshold that wraps instead of saturating.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    typedef struct packed {
        logic p;
        logic n;
    } phase_t;

    typedef struct packed {
        logic hit;
        logic supp;
    } clr_t;

    function automatic logic drive_lvl(input logic act, input logic lvl);
        return act ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/cpwm_tri_cnt.sv
module cpwm_tri_cnt
    import cpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt
);
    dir_e dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            dir_q <= DIR_UP;
        end else if (load) begin
            cnt   <= load_val;
            dir_q <= DIR_UP;
        end else if (run) begin
            if (dir_q == DIR_UP) begin
                if (cnt >= period) begin
                    cnt   <= (cnt == '0) ? cnt : cnt - 1'b1;
                    dir_q <= DIR_DN;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt == '0) begin
                    cnt   <= cnt + 1'b1;
                    dir_q <= DIR_UP;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cpwm_clr_ctl.sv
module cpwm_clr_ctl
    import cpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          clr_req,
    input  logic          sup_en,
    input  logic [CW-1:0] dead,
    input  logic [CW-1:0] lag_cnt,
    input  logic [CW-1:0] lead_cnt,
    output logic          run_q,
    output logic          init_q,
    output logic          tb_q,
    output logic          load
);
    logic start_pulse;
    logic in_trough;
    clr_t clr;

    assign start_pulse = start && !run_q;
    assign in_trough   = (lag_cnt < dead) || (lead_cnt < dead);
    assign clr.hit     = run_q && start && clr_req;
    assign clr.supp    = clr.hit && sup_en && tb_q && !init_q;
    assign load        = start_pulse || clr.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            init_q <= 1'b0;
            tb_q   <= 1'b0;
        end else if (!start) begin
            run_q  <= 1'b0;
            init_q <= 1'b0;
            tb_q   <= 1'b0;
        end else begin
            run_q <= 1'b1;
            tb_q  <= run_q && in_trough;
            if (start_pulse) begin
                init_q <= 1'b1;
            end else if (clr.hit) begin
                init_q <= !clr.supp;
            end else begin
                init_q <= init_q && (lag_cnt < dead);
            end
        end
    end
endmodule

// File: rtl/cpwm_out_stage.sv
module cpwm_out_stage
    import cpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          run_q,
    input  logic          init_q,
    input  logic [CW-1:0] lag_cnt,
    input  logic [CW-1:0] lead_cnt,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] dead,
    input  logic [1:0]    act_lvl,
    output logic          pos_o,
    output logic          neg_o
);
    logic [CW-1:0] neg_thr;
    logic          live;
    phase_t        act;

    assign neg_thr = (duty > dead) ? duty - dead : '0;
    assign live    = run_q && !init_q;
    assign act.p   = live && (lag_cnt > duty);
    assign act.n   = live && (lead_cnt < neg_thr);
    assign pos_o   = drive_lvl(act.p, act_lvl[0]);
    assign neg_o   = drive_lvl(act.n, act_lvl[1]);
endmodule

// File: rtl/cpwm_clrsup.sv
module cpwm_clrsup
    import cpwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          clr_req,
    input  logic          sup_en,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] dead,
    input  logic [CW-1:0] duty,
    input  logic [1:0]    act_lvl,
    output logic          pos_o,
    output logic          neg_o
);
    localparam int NCNT = 2;

    logic [CW-1:0] cnt_q [NCNT];
    logic          run_q;
    logic          init_q;
    logic          tb_q;
    logic          load;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        logic [CW-1:0] ld_v;
        assign ld_v = (g == 0) ? {CW{1'b0}} : dead;
        cpwm_tri_cnt #(.CW(CW)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .run     (run_q),
            .load    (load),
            .load_val(ld_v),
            .period  (period),
            .cnt     (cnt_q[g])
        );
    end

    cpwm_clr_ctl #(.CW(CW)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .clr_req (clr_req),
        .sup_en  (sup_en),
        .dead    (dead),
        .lag_cnt (cnt_q[0]),
        .lead_cnt(cnt_q[1]),
        .run_q   (run_q),
        .init_q  (init_q),
        .tb_q    (tb_q),
        .load    (load)
    );

    cpwm_out_stage #(.CW(CW)) u_out (
        .run_q   (run_q),
        .init_q  (init_q),
        .lag_cnt (cnt_q[0]),
        .lead_cnt(cnt_q[1]),
        .duty    (duty),
        .dead    (dead),
        .act_lvl (act_lvl),
        .pos_o   (pos_o),
        .neg_o   (neg_o)
    );
endmodule

// File: rtl/cpwm_clrsup_chk.sv
module cpwm_clrsup_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       clr_req,
    input logic       sup_en,
    input logic [1:0] act_lvl,
    input logic       pos_o,
    input logic       neg_o,
    input logic       run_q,
    input logic       init_q,
    input logic       tb_q
);
    logic idle;
    logic forced_clr;
    logic supp_clr;

    assign idle       = (pos_o != act_lvl[0]) && (neg_o != act_lvl[1]);
    assign forced_clr = run_q && start && clr_req && !(sup_en && tb_q && !init_q);
    assign supp_clr   = run_q && start && clr_req && sup_en && tb_q && !init_q;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !((pos_o == act_lvl[0]) && (neg_o == act_lvl[1]))); // R5

    AST_START_INIT: assert property (@(posedge clk) disable iff (rst)
        (start && !run_q) |=> idle); // R2

    AST_FORCED_CLEAR: assert property (@(posedge clk) disable iff (rst)
        forced_clr |=> (idle && init_q)); // R6

    AST_SUPP_NO_INIT: assert property (@(posedge clk) disable iff (rst)
        supp_clr |=> !init_q); // R7

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> (idle && !run_q)); // R11
endmodule

bind cpwm_clrsup cpwm_clrsup_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .clr_req(clr_req),
    .sup_en (sup_en),
    .act_lvl(act_lvl),
    .pos_o  (pos_o),
    .neg_o  (neg_o),
    .run_q  (run_q),
    .init_q (init_q),
    .tb_q   (tb_q)
);

// File: tb/cpwm_clrsup_bench.sv
`timescale 1ns/1ps
module cpwm_clrsup_bench;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          clr_req = 1'b0;
    logic          sup_en = 1'b0;
    logic [CW-1:0] period = 8'd10;
    logic [CW-1:0] dead = 8'd2;
    logic [CW-1:0] duty = 8'd8;
    logic [1:0]    act_lvl = 2'b00;
    logic          pos_o;
    logic          neg_o;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference state
    int m_run = 0, m_c1 = 0, m_c2 = 0, m_u1 = 1, m_u2 = 1, m_init = 0, m_tb = 0;

    always #2.5 clk = ~clk;

    cpwm_clrsup #(.CW(CW)) u_cpwm_clrsup (
        .clk(clk), .rst(rst), .start(start), .clr_req(clr_req), .sup_en(sup_en),
        .period(period), .dead(dead), .duty(duty), .act_lvl(act_lvl),
        .pos_o(pos_o), .neg_o(neg_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tri_step(inout int c, inout int u);
        int p = int'(period);
        if (u != 0) begin
            if (c >= p) begin
                c = (c == 0) ? 0 : c - 1;
                u = 0;
            end else c = c + 1;
        end else begin
            if (c == 0) begin
                c = 1;
                u = 1;
            end else c = c - 1;
        end
    endtask

    task automatic model_step();
        int d = int'(dead);
        if (rst) begin
            m_run = 0; m_c1 = 0; m_c2 = 0; m_u1 = 1; m_u2 = 1; m_init = 0; m_tb = 0;
        end else if (!start) begin
            m_run = 0; m_init = 0; m_tb = 0;
        end else if (m_run == 0) begin
            m_run = 1; m_c1 = 0; m_c2 = d; m_u1 = 1; m_u2 = 1; m_init = 1; m_tb = 0;
        end else begin
            int ntb = (m_c1 < d || m_c2 < d) ? 1 : 0;
            if (clr_req) begin
                int sup = (sup_en && m_tb != 0 && m_init == 0) ? 1 : 0;
                m_c1 = 0; m_c2 = d; m_u1 = 1; m_u2 = 1;
                m_init = (sup != 0) ? 0 : 1;
            end else begin
                m_init = (m_init != 0 && m_c1 < d) ? 1 : 0;
                tri_step(m_c1, m_u1);
                tri_step(m_c2, m_u2);
            end
            m_tb = ntb;
        end
    endtask

    task automatic compare();
        int thr = (int'(duty) > int'(dead)) ? int'(duty) - int'(dead) : 0;
        bit live = (m_run != 0) && (m_init == 0);
        bit ap = live && (m_c1 > int'(duty));
        bit an = live && (m_c2 < thr);
        logic ep = ap ? act_lvl[0] : ~act_lvl[0];
        logic en = an ? act_lvl[1] : ~act_lvl[1];
        chk(pos_o === ep, (m_run == 0) ? "R11 pos idle" : "R3 pos compare", int'(pos_o), int'(ep));
        chk(neg_o === en, (m_run == 0) ? "R11 neg idle" : "R4 neg compare", int'(neg_o), int'(en));
        chk(!((pos_o === act_lvl[0]) && (neg_o === act_lvl[1])), "R5 overlap",
            int'({pos_o, neg_o}), int'(~act_lvl));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        repeat (3) tick();
        // R1: reset level, active-low default
        chk(pos_o === 1'b1, "R1 pos reset", int'(pos_o), 1);
        chk(neg_o === 1'b1, "R1 neg reset", int'(neg_o), 1);
        rst = 1'b0;
        tick();

        // R2: initial-output window after start (P=10, D=2, duty=8)
        start = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(pos_o === 1'b1 && neg_o === 1'b1, "R2 init window", int'({pos_o, neg_o}), 3);
        end
        tick();
        chk(neg_o === 1'b0, "R2 window end neg active", int'(neg_o), 0);

        // R6: clear at the peak, enable set, forces window
        sup_en = 1'b1;
        while (!(m_c1 == 10)) tick();
        clr_req = 1'b1;
        tick();
        clr_req = 1'b0;
        chk(pos_o === 1'b1 && neg_o === 1'b1, "R6 forced after clear", int'({pos_o, neg_o}), 3);
        tick();
        tick();
        chk(pos_o === 1'b1 && neg_o === 1'b1, "R6 forced holds", int'({pos_o, neg_o}), 3);
        tick();
        chk(neg_o === 1'b0, "R6 window end", int'(neg_o), 0);

        // R7: clear in trough, enable set, no window
        for (int k = 0; k < 8; k++) tick();
        while (!(m_tb != 0 && m_init == 0)) tick();
        clr_req = 1'b1;
        tick();
        clr_req = 1'b0;
        chk(neg_o === 1'b0, "R7 suppressed clear keeps neg", int'(neg_o), 0);

        // R9: clear in trough, enable clear, window forced
        sup_en = 1'b0;
        for (int k = 0; k < 8; k++) tick();
        while (!(m_tb != 0 && m_init == 0)) tick();
        clr_req = 1'b1;
        tick();
        clr_req = 1'b0;
        chk(neg_o === 1'b1, "R9 unsuppressed clear forces", int'(neg_o), 1);

        // R8: clear in trough during start window
        sup_en = 1'b1;
        start = 1'b0;
        tick();
        start = 1'b1;
        tick();
        tick();
        clr_req = 1'b1;
        tick();
        clr_req = 1'b0;
        chk(neg_o === 1'b1, "R8 init window not suppressed", int'(neg_o), 1);

        // R11: stop and ignored clear
        start = 1'b0;
        tick();
        chk(pos_o === 1'b1 && neg_o === 1'b1, "R11 stopped idle", int'({pos_o, neg_o}), 3);
        clr_req = 1'b1;
        tick();
        clr_req = 1'b0;
        chk(pos_o === 1'b1 && neg_o === 1'b1, "R11 clear ignored", int'({pos_o, neg_o}), 3);

        // R10: active-high levels
        act_lvl = 2'b11;
        tick();
        chk(pos_o === 1'b0 && neg_o === 1'b0, "R10 inactive low", int'({pos_o, neg_o}), 0);
        start = 1'b1;
        for (int k = 0; k < 4; k++) tick();
        chk(neg_o === 1'b1, "R10 neg active high", int'(neg_o), 1);

        // sweep
        for (int p = 3; p <= 8; p++)
            for (int d = 0; d <= 2; d++)
                for (int u = 0; u <= p + 1; u++)
                    for (int s = 0; s < 2; s++) begin
                        start = 1'b0;
                        clr_req = 1'b0;
                        tick();
                        period = p[CW-1:0];
                        dead = d[CW-1:0];
                        duty = u[CW-1:0];
                        sup_en = s[0];
                        act_lvl = 2'((p + d + u) & 3);
                        tick();
                        start = 1'b1;
                        for (int k = 0; k < 4 * p; k++) begin
                            clr_req = (lfsr[2:0] == 3'd0);
                            step_lfsr();
                            tick();
                        end
                    end
        clr_req = 1'b0;
        start = 1'b0;
        tick();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule